// File: doc/BRIEF.md
# Lockable Configuration Bit Store

This block holds a small array of configuration words in registers that stand in for nonvolatile cells. A host drives one command at a time on a parallel strobe interface: verify (read back) a word, program a word, set a security lock, or bulk erase the whole array. Program and erase each take a fixed number of cycles. During that time a busy flag is high and any further strobe is dropped.

Once the lock is set, read-back returns zeros and program requests are refused. Both cases pulse an error flag. The only way to remove the lock is a bulk erase, which also returns every word to the erased state. The erased state is all ones, meaning every connection is intact. The block also counts completed program and erase operations in a saturating counter and raises a wear flag when the counter reaches its limit.

Top module: `cfg_lock_store`

## Requirements
- R1: After reset, every word reads as all ones (0xFF at the default width), `locked` is 0, `busy` is 0, `wear_cnt` is 0 and `wear_flag` is 0.
- R2: Opcode 2'b00 (verify) is accepted on a strobe while not busy. On the next cycle `rd_valid` is 1 and `rd_data` holds the addressed word.
- R3: Opcode 2'b01 (program), when unlocked, holds `busy` high for exactly PROG_CYCLES cycles after the accepting edge. The addressed word holds `cmd_wdata` once `busy` falls.
- R4: Any strobe that arrives while `busy` is high is ignored: it produces no read result, no error and no write.
- R5: The lock is set either by opcode 2'b10 (on the next cycle) or by a program with `cmd_lock_after` = 1 (when that program completes).
- R6: A verify while locked returns `rd_data` = 0 with `rd_valid` = 1 and `err` = 1 for that one cycle.
- R7: A program while locked is refused: `err` pulses for one cycle, `busy` stays low, and `wear_cnt` does not change.
- R8: Opcode 2'b11 (bulk erase) is allowed even while locked. It holds `busy` for exactly ERASE_CYCLES cycles. When it finishes, every word is all ones and `locked` is 0.
- R9: Each completed program or erase adds 1 to `wear_cnt`. The counter saturates at WEAR_LIMIT (1000), and `wear_flag` is 1 exactly when that limit has been reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Opcode: 00 verify, 01 program, 10 set lock, 11 bulk erase |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Program data |
| cmd_lock_after | input | 1 | Set the lock when this program completes |
| rd_valid | output | 1 | Verify result valid |
| rd_data | output | DATA_W | Verify result, zero when locked |
| err | output | 1 | One-cycle pulse for a refused command |
| busy | output | 1 | Program or erase in progress |
| locked | output | 1 | Security lock state |
| wear_cnt | output | CNT_W | Saturating count of completed program and erase operations |
| wear_flag | output | 1 | Wear limit reached |

## Verification
The bench sweeps every address several times:
- from the erased state, which tells the reset contents apart from stale data;
- after programming a distinct address-derived pattern, which tells a correct write apart from an aliased or dropped one;
- after a bulk erase, which tells a full clear apart from a partial one.

Lock behaviour is exercised both ways in. Verify and program are each tried while locked, and the lock is shown to survive until an erase. Strobes issued during busy use data that differs from the stored word, so a wrongly accepted write becomes visible. Repeated erases drive the wear counter through 999, 1000 and one step past, which tells the flag threshold and the saturation apart.

// File: rtl/cfg_lock_store.sv
module cfg_lock_store #(
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 6,
  parameter int WEAR_LIMIT   = 1000,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int TMR_W = $clog2((PROG_CYCLES > ERASE_CYCLES ? PROG_CYCLES : ERASE_CYCLES) + 1),
  localparam int CNT_W = $clog2(WEAR_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_lock_after,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              err,
  output logic              busy,
  output logic              locked,
  output logic [CNT_W-1:0]  wear_cnt,
  output logic              wear_flag
);
  localparam logic [1:0] OP_VERIFY = 2'b00;
  localparam logic [1:0] OP_PROG   = 2'b01;
  localparam logic [1:0] OP_LOCK   = 2'b10;
  localparam logic [1:0] OP_ERASE  = 2'b11;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [TMR_W-1:0]  tmr;
  logic              pend_erase;
  logic              pend_lock;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;

  assign busy      = (tmr != '0);
  assign wear_flag = (wear_cnt == CNT_W'(WEAR_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      tmr        <= '0;
      pend_erase <= 1'b0;
      pend_lock  <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      locked     <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      err        <= 1'b0;
      wear_cnt   <= '0;
    end else begin
      rd_valid <= 1'b0;
      err      <= 1'b0;
      if (busy) begin
        tmr <= tmr - 1'b1;
        if (tmr == TMR_W'(1)) begin
          if (pend_erase) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
            locked <= 1'b0;
          end else begin
            cells[pend_addr] <= pend_data;
            if (pend_lock) locked <= 1'b1;
          end
          if (!wear_flag) wear_cnt <= wear_cnt + 1'b1;
        end
      end else if (cmd_valid) begin
        case (cmd_op)
          OP_VERIFY: begin
            rd_valid <= 1'b1;
            rd_data  <= locked ? '0 : cells[cmd_addr];
            err      <= locked;
          end
          OP_PROG: begin
            if (locked) begin
              err <= 1'b1;
            end else begin
              tmr        <= TMR_W'(PROG_CYCLES);
              pend_erase <= 1'b0;
              pend_lock  <= cmd_lock_after;
              pend_addr  <= cmd_addr;
              pend_data  <= cmd_wdata;
            end
          end
          OP_LOCK: locked <= 1'b1;
          OP_ERASE: begin
            tmr        <= TMR_W'(ERASE_CYCLES);
            pend_erase <= 1'b1;
            pend_lock  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module cfg_lock_store_chk #(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 10,
  parameter int WEAR_LIMIT = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              err,
  input logic              busy,
  input logic              locked,
  input logic [CNT_W-1:0]  wear_cnt,
  input logic              wear_flag
);
  AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (err && rd_valid) |-> (rd_data == '0)); // R6
  AST_NO_READ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(busy)); // R4
  AST_REFUSED_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cmd_valid && !busy && cmd_op == 2'b01) |=> (!busy && err)); // R7
  AST_UNLOCK_ONLY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $fell(busy)); // R8
  AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    wear_cnt >= $past(wear_cnt)); // R9
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    wear_cnt <= CNT_W'(WEAR_LIMIT)); // R9
  AST_WEAR_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wear_flag) |-> ($past(wear_cnt) == CNT_W'(WEAR_LIMIT - 1))); // R9
endmodule

bind cfg_lock_store cfg_lock_store_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .WEAR_LIMIT(WEAR_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rd_valid(rd_valid), .rd_data(rd_data), .err(err), .busy(busy),
  .locked(locked), .wear_cnt(wear_cnt), .wear_flag(wear_flag)
);

// File: tb/sim_cfg_lock_store.sv
`timescale 1ns/1ps
module sim_cfg_lock_store;
  localparam int AW = 3, DW = 8, PC = 4, EC = 6, WL = 1000, CW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_lock_after = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic rd_valid, err, busy, locked, wear_flag;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] wear_cnt;

  int nchk = 0, nfail = 0, exp_cnt = 0;

  always #2 clk = ~clk;

  cfg_lock_store #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .WEAR_LIMIT(WL)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_lock_after(cmd_lock_after), .rd_valid(rd_valid), .rd_data(rd_data),
    .err(err), .busy(busy), .locked(locked), .wear_cnt(wear_cnt), .wear_flag(wear_flag));

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'(a * 29 + k * 7 + 3);
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, int a, logic [DW-1:0] d, logic la);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(a); cmd_wdata = d; cmd_lock_after = la;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_lock_after = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic verify(string req, int a, int exp, logic exp_err);
    issue(2'b00, a, '0, 1'b0);
    chk(req, rd_valid, 1);
    chk(req, rd_data, exp);
    chk(req, err, exp_err);
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1_busy", busy, 0);
    chk("R1_locked", locked, 0);
    chk("R1_cnt", wear_cnt, 0);
    chk("R1_wear", wear_flag, 0);
    chk("R1_rdv", rd_valid, 0);
    rst_n = 1'b1;
    for (int a = 0; a < DEPTH; a++) verify("R1_erased", a, 255, 1'b0);

    for (int a = 0; a < DEPTH; a++) begin
      issue(2'b01, a, pat(a, 1), 1'b0);
      wait_idle(n);
      exp_cnt++;
      chk("R3_busy_len", n, PC);
    end
    for (int a = 0; a < DEPTH; a++) verify("R2_R3_readback", a, pat(a, 1), 1'b0);
    chk("R9_cnt_prog", wear_cnt, exp_cnt);

    issue(2'b01, 2, pat(2, 5), 1'b0);
    issue(2'b01, 3, pat(3, 9), 1'b0);
    issue(2'b00, 3, '0, 1'b0);
    chk("R4_no_read", rd_valid, 0);
    chk("R4_no_err", err, 0);
    wait_idle(n);
    exp_cnt++;
    chk("R4_one_op_cnt", wear_cnt, exp_cnt);
    verify("R4_ignored_write", 3, pat(3, 1), 1'b0);
    verify("R3_write_during", 2, pat(2, 5), 1'b0);

    issue(2'b10, 0, '0, 1'b0);
    chk("R5_lock_cmd", locked, 1);
    for (int a = 0; a < DEPTH; a++) verify("R6_locked_read", a, 0, 1'b1);
    @(negedge clk);
    chk("R6_err_one_cycle", err, 0);
    issue(2'b01, 4, 8'h00, 1'b0);
    chk("R7_err", err, 1);
    chk("R7_no_busy", busy, 0);
    chk("R7_cnt", wear_cnt, exp_cnt);
    chk("R7_still_locked", locked, 1);

    issue(2'b11, 0, '0, 1'b0);
    wait_idle(n);
    exp_cnt++;
    chk("R8_busy_len", n, EC);
    chk("R8_unlocked", locked, 0);
    for (int a = 0; a < DEPTH; a++) verify("R8_erased", a, 255, 1'b0);

    issue(2'b01, 6, pat(6, 2), 1'b1);
    chk("R5_not_yet", locked, 0);
    wait_idle(n);
    exp_cnt++;
    chk("R5_lock_after", locked, 1);
    verify("R5_R6_read", 6, 0, 1'b1);
    issue(2'b11, 0, '0, 1'b0);
    wait_idle(n);
    exp_cnt++;
    verify("R8_after_lock", 6, 255, 1'b0);
    chk("R9_cnt", wear_cnt, exp_cnt);

    while (exp_cnt < WL - 1) begin
      issue(2'b11, 0, '0, 1'b0);
      wait_idle(n);
      exp_cnt++;
    end
    chk("R9_cnt_999", wear_cnt, WL - 1);
    chk("R9_flag_low", wear_flag, 0);
    issue(2'b11, 0, '0, 1'b0);
    wait_idle(n);
    chk("R9_cnt_1000", wear_cnt, WL);
    chk("R9_flag_high", wear_flag, 1);
    issue(2'b01, 1, pat(1, 3), 1'b0);
    wait_idle(n);
    chk("R9_saturate", wear_cnt, WL);
    verify("R3_after_wear", 1, pat(1, 3), 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule